// File: doc/BRIEF.md
# Decimal Key Priority Encoder

This block turns the state of a ten-key decimal keypad into a four-bit binary-coded-decimal digit. Keys 1 to 9 feed a priority encoder through active-low lines. When more than one of them is held, only the highest-numbered key is encoded. The result leaves the block active-low, so the pins carry the bitwise complement of the digit's code.

Key 0 has no line into the encoder. The digit zero is what the encoder reports when no key from 1 to 9 is held, so all four output pins sit high. A key-0 press and an idle keypad therefore give the same code. The zero key has its own active-low input for that reason. It feeds only a separate press-detect flag, which lets the surrounding logic tell a real zero from no press. The block is purely combinational: it has no clock or reset, and it holds no state.

Top module: `key_prio_encoder`

## Requirements
- R1: When every key input is high (no key held), `code_n_o` is 4'b1111, meaning digit 0, and `key_pressed_o` is 0.
- R2: When a single key d (1..9) is held, the pin `key_n_i[d-1]` is driven low and `code_n_o` equals the bitwise complement of d as a 4-bit binary number. For example, key 3 alone gives 4'b1100, key 1 alone gives 4'b1110 and key 9 alone gives 4'b0110.
- R3: When several of keys 1..9 are held together, `code_n_o` is the complement of the highest held key number. Lower held keys have no effect on it.
- R4: `zero_key_n_i` has no effect on `code_n_o` for any state of the other keys.
- R5: `key_pressed_o` is 1 exactly when at least one of the ten key inputs (zero key included) is low. The zero key alone is enough to raise it.
- R6: The complement of `code_n_o` never exceeds 9 for any combination of inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| key_n_i | input | 9 | Active-low keys 1..9; bit k-1 is key k |
| zero_key_n_i | input | 1 | Active-low zero key, used only for press detection |
| code_n_o | output | 4 | Active-low BCD code of the highest held key |
| key_pressed_o | output | 1 | High when any of the ten keys is held |

## Verification
The bench drives every one of the 1024 combinations of the ten key lines. For each one it compares both outputs against its own search for the highest low key.

- Inverted priority (lowest key wins) shows up on any pattern where two keys are held together.
- An output left active-high reads 0000 when the keypad is idle.
- An encoder that lets the zero key disturb the code changes its output when only the zero line toggles.
- A press flag that ignores the zero key stays low for a zero pressed alone.
- An off-by-one in the digit numbering is exposed by key 1 alone and key 9 alone.

// File: rtl/kpe_pkg.sv
// Package: shared constants and helpers for the decimal key priority encoder.
// Assumes keys are numbered from 1 upward and the digit 0 is implied by no key.
package kpe_pkg;

    // Number of keys that feed the encoder (keys 1..9)
    localparam int unsigned KPE_DIGITS = 9;

    // Width of a code able to hold every value from 0 to n
    function automatic int unsigned kpe_code_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/kpe_key_sense.sv
// Module: kpe_key_sense
// Converts the active-low key lines into active-high "held" flags.
// Assumes the key lines are already clean levels, with no bounce filtering here.
module kpe_key_sense #(
    parameter int unsigned N = 9
) (
    input  logic [N-1:0] key_n,
    input  logic         zero_n,
    output logic [N-1:0] held,
    output logic         zero_held
);

    // One inverter per encoded key line
    for (genvar g = 0; g < N; g++) begin : g_inv
        assign held[g] = ~key_n[g];
    end

    // Zero key inversion, kept apart from the encoded keys
    assign zero_held = ~zero_n;

endmodule

// File: rtl/kpe_prio_pick.sv
// Module: kpe_prio_pick
// Finds the highest-numbered held key and gives its number (bit i is key i+1).
// Assumes W is wide enough to hold N; the result is 0 when no key is held.
module kpe_prio_pick #(
    parameter int unsigned N = 9,
    parameter int unsigned W = 4
) (
    input  logic [N-1:0] held,
    output logic [W-1:0] digit,
    output logic         any_held
);

    // Ascending scan: the last held key seen (the highest) sets the digit
    always_comb begin
        digit = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (held[i]) begin
                digit = W'(i + 1);
            end
        end
    end

    // Reduction flag showing that some encoded key is held
    assign any_held = |held;

endmodule

// File: rtl/kpe_code_out.sv
// Module: kpe_code_out
// Drives the active-low code pins and the press-detect flag.
// Assumes the digit input is already the priority-resolved key number.
module kpe_code_out #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] digit,
    input  logic         any_held,
    input  logic         zero_held,
    output logic [W-1:0] code_n,
    output logic         pressed
);

    // Active-low output polarity
    assign code_n = ~digit;

    // A press is any encoded key or the zero key
    assign pressed = any_held | zero_held;

endmodule

// File: rtl/key_prio_encoder.sv
// Module: key_prio_encoder
// Top of the decimal key priority encoder. Keys 1..9 feed a highest-wins
// encoder whose BCD result leaves the block active-low. The zero key only
// contributes to the press flag.
// Assumes a combinational use: no clock, reset or storage inside the block.
module key_prio_encoder
    import kpe_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = KPE_DIGITS,
    parameter int unsigned CODE_W     = kpe_code_width(NUM_DIGITS)
) (
    input  logic [NUM_DIGITS-1:0] key_n_i,
    input  logic                  zero_key_n_i,
    output logic [CODE_W-1:0]     code_n_o,
    output logic                  key_pressed_o
);

    logic [NUM_DIGITS-1:0] digit_act;
    logic                  zero_act;
    logic [CODE_W-1:0]     win_digit;
    logic                  any_act;

    // Input polarity stage
    kpe_key_sense #(.N(NUM_DIGITS)) u_sense (
        .key_n     (key_n_i),
        .zero_n    (zero_key_n_i),
        .held      (digit_act),
        .zero_held (zero_act)
    );

    // Priority resolution stage
    kpe_prio_pick #(.N(NUM_DIGITS), .W(CODE_W)) u_pick (
        .held     (digit_act),
        .digit    (win_digit),
        .any_held (any_act)
    );

    // Output polarity and press-detect stage
    kpe_code_out #(.W(CODE_W)) u_out (
        .digit     (win_digit),
        .any_held  (any_act),
        .zero_held (zero_act),
        .code_n    (code_n_o),
        .pressed   (key_pressed_o)
    );

endmodule

// File: rtl/kpe_checker.sv
// Module: kpe_checker
// Immediate assertions on the encoder's ports and its internal stages.
// Assumes it is bound to key_prio_encoder; it has no clock because the block has none.
module kpe_checker #(
    parameter int unsigned N = 9,
    parameter int unsigned W = 4
) (
    input logic [N-1:0] key_n_i,
    input logic         zero_key_n_i,
    input logic [W-1:0] code_n_o,
    input logic         key_pressed_o,
    input logic [N-1:0] digit_act,
    input logic [W-1:0] win_digit
);

    int   top_ref;
    logic above_hit;

    // Independent reference: the highest low key line seen at the ports
    always_comb begin
        top_ref = 0;
        for (int i = 0; i < int'(N); i++) begin
            if (!key_n_i[i]) begin
                top_ref = i + 1;
            end
        end
    end

    // Search for a held key ranked above the resolved winner
    always_comb begin
        above_hit = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if ((i + 1 > int'(win_digit)) && digit_act[i]) begin
                above_hit = 1'b1;
            end
        end
    end

    // Port-level and stage-level checks
    always_comb begin
        AST_IDLE_ZERO: assert (!(&key_n_i) || (&code_n_o)); // R1
        AST_TOP_KEY: assert (code_n_o == ~(W'(top_ref))); // R3
        AST_NONE_ABOVE: assert (!above_hit); // R3
        AST_PRESS_FLAG: assert (key_pressed_o == ((~zero_key_n_i) | (top_ref != 0))); // R5
        AST_CODE_RANGE: assert (int'(~code_n_o) <= int'(N)); // R6
    end

endmodule

bind key_prio_encoder kpe_checker #(.N(NUM_DIGITS), .W(CODE_W)) u_chk (
    .key_n_i       (key_n_i),
    .zero_key_n_i  (zero_key_n_i),
    .code_n_o      (code_n_o),
    .key_pressed_o (key_pressed_o),
    .digit_act     (digit_act),
    .win_digit     (win_digit)
);

// File: tb/sim_key_prio_encoder.sv
// Bench: vector table walk, then an exhaustive sweep and directed zero-key checks.
module sim_key_prio_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // Vector layout: {zero_n, keys_n[8:0], expected code_n[3:0], expected press, req tag[3:0]}
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 9'h1FF, 4'hF, 1'b0, 4'd1},  // R1 idle keypad
        {1'b0, 9'h1FF, 4'hF, 1'b1, 4'd5},  // R5 zero key alone
        {1'b1, 9'h1FB, 4'hC, 1'b1, 4'd2},  // R2 key 3 alone
        {1'b1, 9'h1FE, 4'hE, 1'b1, 4'd2},  // R2 key 1 alone
        {1'b1, 9'h0FF, 4'h6, 1'b1, 4'd2},  // R2 key 9 alone
        {1'b0, 9'h000, 4'h6, 1'b1, 4'd3},  // R3 all keys held
        {1'b1, 9'h1AD, 4'h8, 1'b1, 4'd3},  // R3 keys 2,5,7
        {1'b0, 9'h17F, 4'h7, 1'b1, 4'd4},  // R4 key 8 with zero
        {1'b1, 9'h1F7, 4'hB, 1'b1, 4'd2},  // R2 key 4 alone
        {1'b1, 9'h1C0, 4'h9, 1'b1, 4'd3}   // R3 keys 1..6
    };

    logic       clk = 1'b0;
    logic [8:0] key_n;
    logic       zero_n;
    logic [3:0] code_n;
    logic       pressed;
    int         checks = 0;
    int         fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    key_prio_encoder u0 (
        .key_n_i       (key_n),
        .zero_key_n_i  (zero_n),
        .code_n_o      (code_n),
        .key_pressed_o (pressed)
    );

    // Compare one observed value against its expected value
    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply inputs on the falling edge and sample at the next rising edge
    task automatic apply(input logic z, input logic [8:0] k);
        @(negedge clk);
        zero_n = z;
        key_n  = k;
        @(posedge clk);
    endtask

    // Watchdog: a hung run counts as one failure and still reports
    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] ref_code;
        logic [3:0] held_code;
        int         top;

        zero_n = 1'b1;
        key_n  = 9'h1FF;

        // R1 power-up state: idle keypad reads as digit 0 with no press
        @(posedge clk);
        check("R1 idle code", code_n, 4'hF);
        check("R1 idle press", {3'b0, pressed}, 4'h0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][18], VEC[v][17:9]);
            check($sformatf("R%0d vec%0d code", VEC[v][3:0], v), code_n, VEC[v][8:5]);
            check($sformatf("R%0d vec%0d press", VEC[v][3:0], v), {3'b0, pressed}, {3'b0, VEC[v][4]});
        end

        // Exhaustive sweep against a highest-low-key search (R3, R5, R6)
        for (int v = 0; v < 1024; v++) begin
            apply(v[9], v[8:0]);
            top = 0;
            for (int i = 0; i < 9; i++) begin
                if (!v[i]) top = i + 1;
            end
            ref_code = ~(4'(top));
            check("R3 sweep code", code_n, ref_code);
            check("R5 sweep press", {3'b0, pressed}, {3'b0, (!v[9]) || (top != 0)});
            check("R6 sweep range", {3'b0, (~code_n) <= 4'd9}, 4'h1);
        end

        // R4: toggling only the zero key leaves the code unchanged
        for (int k = 0; k < 9; k++) begin
            apply(1'b1, ~(9'(1) << k));
            held_code = code_n;
            apply(1'b0, ~(9'(1) << k));
            check("R4 zero toggle", code_n, held_code);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule